// File: doc/BRIEF.md
# 4x4 Residual Forward Transform Engine

This block turns one 4x4 block of 8-bit source pixels and its 4x4 block of 8-bit prediction pixels into sixteen signed 16-bit transform coefficients. It uses the fixed-point integer approximation of the DCT found in VP8-style encoders. The residual (source minus prediction) is first transformed along each row by a butterfly with a fixed-point rotation. The block is then transformed down each column with different rounding constants and a one-count correction on the first odd coefficient. The result matches the integer equations bit for bit.

A block enters in a single valid/ready transfer and leaves in a single valid/ready transfer. A state machine with four states sequences the work.
- `ST_IDLE` waits for input. Transition *accept* (in_valid while idle) captures the residuals and moves to `ST_ROWS`.
- `ST_ROWS` spends one cycle per row. Transition *rows_done* (after the last row) moves to `ST_COLS`.
- `ST_COLS` spends one cycle per column. Transition *cols_done* moves to `ST_HOLD`.
- `ST_HOLD` presents the coefficients until transition *drain* (out_ready) returns to `ST_IDLE`.

Top module: `blk4_fwd_xform`

## Requirements
- R1: Pixel (row r, column c) of `src_blk` and `pred_blk` sits at bits [8*(4r+c) +: 8]. Each residual is the unsigned source pixel minus the unsigned prediction pixel, taken as a signed value in the range -255..255.
- R2: The row pass runs on each row's residuals d0..d3. It forms a0=d0+d3, a1=d1+d2, a2=d1-d2, a3=d0-d3. Its outputs 0 and 2 are (a0+a1)*8 and (a0-a1)*8.
- R3: Row pass output 1 is (a2*2217 + a3*5352 + 1812) >>> 9. Row pass output 3 is (a3*2217 - a2*5352 + 937) >>> 9. Both use 32-bit arithmetic.
- R4: The column pass takes, for column u, the row-pass output u of rows 0..3 as d0..d3. It uses the same butterfly. Its outputs 0 and 2 are (a0+a1+7) >>> 4 and (a0-a1+7) >>> 4.
- R5: Column pass output 1 is ((a2*2217 + a3*5352 + 12000) >>> 16) + 1 when a3 is nonzero, and + 0 when a3 is zero.
- R6: Column pass output 3 is (a3*2217 - a2*5352 + 51000) >>> 16.
- R7: The coefficient of vertical frequency v and column u appears as a two's-complement value at `coef` bits [16*(4v+u) +: 16].
- R8: `in_ready` is high only in the idle state. A block is taken only on a cycle where `in_valid` and `in_ready` are both high. Input offered while a block is in flight or waiting is not taken and does not alter the result.
- R9: `out_valid` rises 9 cycles after the accepting clock edge. It then stays high with `coef` unchanged until a cycle with `out_ready` high, after which it falls and `in_ready` rises.
- R10: After reset, `in_ready` is high and `out_valid` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | A pixel block pair is offered |
| in_ready | output | 1 | Engine is idle and takes the offered block |
| src_blk | input | 128 | Sixteen source pixels, packed per R1 |
| pred_blk | input | 128 | Sixteen prediction pixels, packed per R1 |
| out_valid | output | 1 | Coefficients are available |
| out_ready | input | 1 | Consumer takes the coefficients |
| coef | output | 256 | Sixteen signed coefficients, packed per R7 |

## Verification
Two things can coincide in one cycle: a new block offered on the input while the previous result still waits for `out_ready`. The bench provokes this on every vector. After each acceptance it keeps `in_valid` high with unrelated pixel data through the whole computation and through a hold of random length with `out_ready` low. It then judges three things against the arithmetic model: `in_ready` stayed low, the held coefficients are still those of the first block, and the first block's coefficients still match after the hold. The sweep covers every uniform residual from -255 to +255, a ±255 impulse at each of the sixteen positions, an alternating ±255 pattern, and random blocks.

// File: rtl/fx_pkg.sv
package fx_pkg;
    // block geometry
    localparam int N      = 4;
    localparam int NPIX   = N * N;
    localparam int IDX_W  = $clog2(N);
    // data widths
    localparam int PIX_W  = 8;
    localparam int CF_W   = 16;
    localparam int ACC_W  = 32;
    // rotation multipliers shared by both passes
    localparam int ROT_A  = 2217;
    localparam int ROT_B  = 5352;
    // row pass scaling and rounding
    localparam int ROW_UP   = 3;
    localparam int ROW_SH   = 9;
    localparam int ROW_RND1 = 1812;
    localparam int ROW_RND3 = 937;
    // column pass scaling and rounding
    localparam int COL_RNDE = 7;
    localparam int COL_SHE  = 4;
    localparam int COL_SHO  = 16;
    localparam int COL_RND1 = 12000;
    localparam int COL_RND3 = 51000;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ROWS,
        ST_COLS,
        ST_HOLD
    } fx_state_e;
endpackage

// File: rtl/fx_bfly.sv
module fx_bfly
    import fx_pkg::*;
#(
    parameter bit COL_PASS = 1'b0
) (
    input  logic signed [CF_W-1:0] d [N],
    output logic signed [CF_W-1:0] y [N]
);
    localparam logic signed [ACC_W-1:0] KA = ACC_W'(ROT_A);
    localparam logic signed [ACC_W-1:0] KB = ACC_W'(ROT_B);

    logic signed [ACC_W-1:0] a0, a1, a2, a3;

    // shared butterfly, widened before any arithmetic
    always_comb begin
        a0 = ACC_W'(d[0]) + ACC_W'(d[3]);
        a1 = ACC_W'(d[1]) + ACC_W'(d[2]);
        a2 = ACC_W'(d[1]) - ACC_W'(d[2]);
        a3 = ACC_W'(d[0]) - ACC_W'(d[3]);
    end

    generate
        if (!COL_PASS) begin : g_row
            localparam logic signed [ACC_W-1:0] R1C = ACC_W'(ROW_RND1);
            localparam logic signed [ACC_W-1:0] R3C = ACC_W'(ROW_RND3);
            always_comb begin
                y[0] = CF_W'((a0 + a1) <<< ROW_UP);
                y[2] = CF_W'((a0 - a1) <<< ROW_UP);
                y[1] = CF_W'((a2 * KA + a3 * KB + R1C) >>> ROW_SH);
                y[3] = CF_W'((a3 * KA - a2 * KB + R3C) >>> ROW_SH);
            end
        end else begin : g_col
            localparam logic signed [ACC_W-1:0] REC = ACC_W'(COL_RNDE);
            localparam logic signed [ACC_W-1:0] R1C = ACC_W'(COL_RND1);
            localparam logic signed [ACC_W-1:0] R3C = ACC_W'(COL_RND3);
            logic signed [CF_W-1:0] odd1_base;
            logic                   nz_fix;
            always_comb begin
                y[0]      = CF_W'((a0 + a1 + REC) >>> COL_SHE);
                y[2]      = CF_W'((a0 - a1 + REC) >>> COL_SHE);
                odd1_base = CF_W'((a2 * KA + a3 * KB + R1C) >>> COL_SHO);
                nz_fix    = (a3 != '0);
                y[1]      = odd1_base + {{(CF_W-1){1'b0}}, nz_fix};
                y[3]      = CF_W'((a3 * KA - a2 * KB + R3C) >>> COL_SHO);
            end
        end
    endgenerate
endmodule

// File: rtl/fx_fsm.sv
module fx_fsm
    import fx_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             out_ready,
    output logic             in_ready,
    output logic             out_valid,
    output logic             cap,
    output logic             row_en,
    output logic             col_en,
    output logic [IDX_W-1:0] idx
);
    fx_state_e        st_q, st_d;
    logic [IDX_W-1:0] idx_q;
    logic             last;

    assign last = (idx_q == IDX_W'(N - 1));
    assign idx  = idx_q;

    // state register and row/column index
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= ST_IDLE;
            idx_q <= '0;
        end else begin
            st_q <= st_d;
            if (st_d != st_q)
                idx_q <= '0;
            else if (st_q == ST_ROWS || st_q == ST_COLS)
                idx_q <= idx_q + 1'b1;
        end
    end

    // transitions: accept, rows_done, cols_done, drain
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: if (in_valid)  st_d = ST_ROWS;
            ST_ROWS: if (last)      st_d = ST_COLS;
            ST_COLS: if (last)      st_d = ST_HOLD;
            ST_HOLD: if (out_ready) st_d = ST_IDLE;
            default:                st_d = ST_IDLE;
        endcase
    end

    // outputs decoded from state
    always_comb begin
        in_ready  = 1'b0;
        out_valid = 1'b0;
        row_en    = 1'b0;
        col_en    = 1'b0;
        unique case (st_q)
            ST_IDLE: in_ready  = 1'b1;
            ST_ROWS: row_en    = 1'b1;
            ST_COLS: col_en    = 1'b1;
            ST_HOLD: out_valid = 1'b1;
            default: in_ready  = 1'b0;
        endcase
        cap = in_ready && in_valid;
    end
endmodule

// File: rtl/blk4_fwd_xform.sv
module blk4_fwd_xform
    import fx_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   in_valid,
    output logic                   in_ready,
    input  logic [NPIX*PIX_W-1:0]  src_blk,
    input  logic [NPIX*PIX_W-1:0]  pred_blk,
    output logic                   out_valid,
    input  logic                   out_ready,
    output logic [NPIX*CF_W-1:0]   coef
);
    logic             cap, row_en, col_en;
    logic [IDX_W-1:0] idx;

    logic signed [CF_W-1:0] res_q [NPIX];
    logic signed [CF_W-1:0] mid_q [NPIX];
    logic signed [CF_W-1:0] cf_q  [NPIX];

    logic signed [CF_W-1:0] row_d [N];
    logic signed [CF_W-1:0] row_y [N];
    logic signed [CF_W-1:0] col_d [N];
    logic signed [CF_W-1:0] col_y [N];

    fx_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .out_ready (out_ready),
        .in_ready  (in_ready),
        .out_valid (out_valid),
        .cap       (cap),
        .row_en    (row_en),
        .col_en    (col_en),
        .idx       (idx)
    );

    fx_bfly #(.COL_PASS(1'b0)) u_row (.d(row_d), .y(row_y));
    fx_bfly #(.COL_PASS(1'b1)) u_col (.d(col_d), .y(col_y));

    // operand selection: a row of residuals, a column of row results
    genvar k;
    generate
        for (k = 0; k < N; k++) begin : g_sel
            assign row_d[k] = res_q[{idx, IDX_W'(k)}];
            assign col_d[k] = mid_q[{IDX_W'(k), idx}];
        end
    endgenerate

    // per-element storage
    genvar g;
    generate
        for (g = 0; g < NPIX; g++) begin : g_cell
            logic [CF_W-1:0] s_ext, p_ext;
            assign s_ext = {{(CF_W-PIX_W){1'b0}}, src_blk[g*PIX_W +: PIX_W]};
            assign p_ext = {{(CF_W-PIX_W){1'b0}}, pred_blk[g*PIX_W +: PIX_W]};

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    res_q[g] <= '0;
                    mid_q[g] <= '0;
                    cf_q[g]  <= '0;
                end else begin
                    if (cap)
                        res_q[g] <= signed'(s_ext - p_ext);
                    if (row_en && idx == IDX_W'(g / N))
                        mid_q[g] <= row_y[g % N];
                    if (col_en && idx == IDX_W'(g % N))
                        cf_q[g]  <= col_y[g / N];
                end
            end

            assign coef[g*CF_W +: CF_W] = cf_q[g];
        end
    endgenerate
endmodule

// File: rtl/fx_chk.sv
module fx_chk
    import fx_pkg::*;
(
    input logic                 clk,
    input logic                 rst_n,
    input logic                 in_valid,
    input logic                 in_ready,
    input logic                 out_valid,
    input logic                 out_ready,
    input logic [NPIX*CF_W-1:0] coef
);
    // R8
    ready_valid_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_ready && out_valid));

    // R8
    accept_closes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> !in_ready);

    // R9
    latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |-> ##9 out_valid);

    // R9
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(coef)));

    // R9
    drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready) |=> (!out_valid && in_ready));
endmodule

bind blk4_fwd_xform fx_chk i_fx_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .coef      (coef)
);

// File: tb/test_blk4_fwd_xform.sv
module test_blk4_fwd_xform;
    localparam int CLK_PERIOD = 10;
    localparam int WD_CYCLES  = 150000;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic         in_ready;
    logic [127:0] src_blk = '0;
    logic [127:0] pred_blk = '0;
    logic         out_valid;
    logic         out_ready = 1'b0;
    logic [255:0] coef;

    int  n_vec = 0;
    int  n_bad = 0;
    bit  done  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    blk4_fwd_xform i_blk4_fwd_xform (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .src_blk   (src_blk),
        .pred_blk  (pred_blk),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .coef      (coef)
    );

    // arithmetic model written from the requirements
    function automatic logic [255:0] model(input logic [127:0] s, input logic [127:0] p);
        int r [16];
        int t [16];
        int v [16];
        logic [255:0] o;
        for (int k = 0; k < 16; k++)                       // R1
            r[k] = int'(s[8*k +: 8]) - int'(p[8*k +: 8]);
        for (int i = 0; i < 4; i++) begin                  // R2, R3
            int a0, a1, a2, a3;
            a0 = r[4*i] + r[4*i+3];
            a1 = r[4*i+1] + r[4*i+2];
            a2 = r[4*i+1] - r[4*i+2];
            a3 = r[4*i] - r[4*i+3];
            t[4*i]   = (a0 + a1) * 8;
            t[4*i+2] = (a0 - a1) * 8;
            t[4*i+1] = (a2 * 2217 + a3 * 5352 + 1812) >>> 9;
            t[4*i+3] = (a3 * 2217 - a2 * 5352 + 937) >>> 9;
        end
        for (int u = 0; u < 4; u++) begin                  // R4, R5, R6
            int a0, a1, a2, a3, hi;
            a0 = t[u] + t[12+u];
            a1 = t[4+u] + t[8+u];
            a2 = t[4+u] - t[8+u];
            a3 = t[u] - t[12+u];
            v[u]    = (a0 + a1 + 7) >>> 4;
            v[8+u]  = (a0 - a1 + 7) >>> 4;
            hi      = (a2 * 2217 + a3 * 5352 + 12000) >>> 16;
            v[4+u]  = hi + ((a3 != 0) ? 1 : 0);
            v[12+u] = (a3 * 2217 - a2 * 5352 + 51000) >>> 16;
        end
        for (int k = 0; k < 16; k++)                       // R7
            o[16*k +: 16] = 16'(v[k]);
        return o;
    endfunction

    function automatic string coef_tag(input int k);
        case (k / 4)
            0, 2:    return "R1,R2,R3,R7,R4";
            1:       return "R1,R2,R3,R7,R5";
            default: return "R1,R2,R3,R7,R6";
        endcase
    endfunction

    task automatic check_coef(input string when, input logic [255:0] exp);
        n_vec++;
        if (coef !== exp) begin
            int bad_k;
            bad_k = 0;
            for (int k = 15; k >= 0; k--)
                if (coef[16*k +: 16] !== exp[16*k +: 16]) bad_k = k;
            n_bad++;
            $display("FAIL %s %s coef[%0d] actual %0d expected %0d", coef_tag(bad_k), when,
                     bad_k, $signed(coef[16*bad_k +: 16]), $signed(exp[16*bad_k +: 16]));
        end
    endtask

    task automatic check_bit(input string tag, input logic act, input logic exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual %b expected %b", tag, act, exp);
        end
    endtask

    task automatic run_block(input logic [127:0] s, input logic [127:0] p, input int hold);
        logic [255:0] exp;
        int lat;
        exp = model(s, p);
        @(negedge clk);
        src_blk  = s;
        pred_blk = p;
        in_valid = 1'b1;
        while (!in_ready) @(negedge clk);
        @(negedge clk);
        lat = 1;
        // offer an unrelated block while this one is in flight (R8)
        src_blk  = ~s;
        pred_blk = p ^ {4{$urandom()}};
        check_bit("R8 in_ready while busy", in_ready, 1'b0);
        while (!out_valid && lat < 20) begin
            @(negedge clk);
            lat++;
        end
        n_vec++;
        if (lat != 9) begin
            n_bad++;
            $display("FAIL R9 latency actual %0d expected %0d", lat, 9);
        end
        check_coef("first sight", exp);
        for (int h = 0; h < hold; h++) begin
            @(negedge clk);
            check_bit("R8 in_ready during hold", in_ready, 1'b0);
        end
        if (hold > 0) begin
            check_bit("R9 out_valid held", out_valid, 1'b1);
            check_coef("R9 after hold", exp);
        end
        in_valid  = 1'b0;
        out_ready = 1'b1;
        @(negedge clk);
        out_ready = 1'b0;
        check_bit("R9 out_valid after drain", out_valid, 1'b0);
        check_bit("R9 in_ready after drain", in_ready, 1'b1);
    endtask

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        if (!done) begin
            n_vec++;
            n_bad++;
            $display("FAIL R9 watchdog actual busy after %0d cycles expected completion", WD_CYCLES);
            $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        logic [127:0] s, p;
        repeat (3) @(negedge clk);
        // R10 reset state
        check_bit("R10 in_ready at reset", in_ready, 1'b1);
        check_bit("R10 out_valid at reset", out_valid, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        check_bit("R10 in_ready after reset", in_ready, 1'b1);
        check_bit("R10 out_valid after reset", out_valid, 1'b0);

        // all-zero residual at a nonzero pixel level
        run_block({16{8'd77}}, {16{8'd77}}, 2);

        // uniform residual sweep -255..255 (R1 sign handling)
        for (int d = -255; d <= 255; d++) begin
            logic [7:0] sv, pv;
            sv = (d >= 0) ? 8'(d) : 8'd0;
            pv = (d >= 0) ? 8'd0 : 8'(-d);
            run_block({16{sv}}, {16{pv}}, (d & 3));
        end

        // impulse of +255 and -255 at every position (R7 ordering)
        for (int k = 0; k < 16; k++) begin
            s = '0; p = '0;
            s[8*k +: 8] = 8'hFF;
            run_block(s, p, 0);
            s = '0; p = '0;
            p[8*k +: 8] = 8'hFF;
            run_block(s, p, 1);
        end

        // alternating extremes
        for (int k = 0; k < 16; k++) begin
            s[8*k +: 8] = (((k / 4) + k) % 2 == 0) ? 8'hFF : 8'h00;
            p[8*k +: 8] = ~s[8*k +: 8];
        end
        run_block(s, p, 3);

        // random blocks
        for (int n = 0; n < 300; n++) begin
            s = {$urandom(), $urandom(), $urandom(), $urandom()};
            p = {$urandom(), $urandom(), $urandom(), $urandom()};
            run_block(s, p, int'($urandom_range(0, 3)));
        end

        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule